// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block generates the system reset for a processor subsystem. It combines three reset sources: power-on, a low-supply flag, and a watchdog. The power-on source is the raw power-good reset `rst_ni`. The low-supply flag comes from an external comparator and arrives already synchronous to the clock. The watchdog is restarted by pulses on the serial chip-select line. Every source stretches the reset it causes by a fixed number of clock cycles, so the supply and the clock can settle before software runs.

The watchdog period comes from a 2-bit select. Three codes give three preset intervals, and the fourth code turns the watchdog off. The select is static configuration: it is changed only while `rst_ni` is low. A status flag records whether the most recent reset came from the watchdog. It is cleared by power-on and by a low-supply event. All intervals are cycle-count parameters.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_o` is 1 and `cause_wd_o` is 0. After `rst_ni` rises, `sys_rst_o` falls on the POR_CYCLES-th rising clock edge.
- R2: A 1 sampled on `low_supply_i` asserts `sys_rst_o` from that clock edge onward. The reset stays asserted for as long as the flag is sampled high.
- R3: After the last edge that samples `low_supply_i` high, `sys_rst_o` falls on the HOLD_CYCLES-th following rising edge. A low-supply pulse sampled high on L edges therefore gives a reset that is high for L+HOLD_CYCLES-1 cycles.
- R4: Without kicks, the watchdog asserts reset exactly PER cycles after the edge that released the previous reset. PER is WD_SHORT for code 2'b10, WD_MID for 2'b01 and WD_LONG for 2'b00. The counter is held cleared while reset is asserted.
- R5: A watchdog timeout keeps `sys_rst_o` high for exactly HOLD_CYCLES cycles.
- R6: A kick is a low pulse on `wdi_cs_ni`, sampled low on at least KICK_MIN consecutive edges and then returned high. It restarts the period on the third rising edge after `wdi_cs_ni` is first sampled high again. A kick sent after the k-th edge following reset release therefore gives a gap of k+KICK_MIN+3+PER cycles. Shorter low pulses have no effect.
- R7: Code 2'b11 disables the watchdog: it never times out and kicks are ignored. Low-supply resets still work.
- R8: `sys_rst_no` is always the complement of `sys_rst_o`.
- R9: A watchdog timeout sets `cause_wd_o` to 1. A low-supply event or power-on sets it to 0. The flag holds its value after reset is released, until the next cause occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Raw power-good reset, active low, asynchronous |
| low_supply_i | input | 1 | Low-supply flag from comparator, synchronous, active high |
| wdi_cs_ni | input | 1 | Chip-select used as watchdog kick, active low |
| wd_sel_i | input | 2 | Watchdog period select (static) |
| sys_rst_o | output | 1 | System reset, active high |
| sys_rst_no | output | 1 | System reset, active low |
| cause_wd_o | output | 1 | 1: last reset came from the watchdog |

## Verification
The checker verifies these properties on every cycle:
- The two reset outputs are complements of each other.
- A sampled low-supply flag forces reset on the next edge and clears the cause flag.
- Reset never falls while the supply flag was just high.
- A watchdog expiry produces a reset flagged as a watchdog reset.
- The disabled code never expires.
- No reset pulse is shorter than the shorter of the two stretch counts.

Only the bench scenarios can show the exact cycle counts. These are the reset widths, the per-code timeout gap, the three-cycle delay from a kick to the restart of the period, and the rejection of a pulse one cycle below the minimum width.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rsup_kick_detect.sv
module rsup_kick_detect #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_LOW     = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  output logic kick_o
);
  localparam int unsigned CW = $clog2(MIN_LOW + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   cs_d;
  logic [CW-1:0]          low_cnt;
  logic                   cs_s;

  assign cs_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], cs_ni};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d    <= 1'b1;
      low_cnt <= '0;
    end else begin
      cs_d <= cs_s;
      if (cs_s)                         low_cnt <= '0;
      else if (low_cnt != CW'(MIN_LOW)) low_cnt <= low_cnt + 1'b1;
    end
  end

  // rising edge of the synchronized select, after a long enough low phase
  assign kick_o = cs_s & ~cs_d & (low_cnt >= CW'(MIN_LOW));
endmodule

// File: rtl/rsup_wdt.sv
module rsup_wdt
  import rsup_pkg::*;
#(
  parameter int unsigned P_SHORT = 60,
  parameter int unsigned P_MID   = 100,
  parameter int unsigned P_LONG  = 150
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hold_i,
  input  logic [1:0] sel_i,
  input  logic       kick_i,
  output logic       expire_o
);
  localparam int unsigned PMAX = max2(max2(P_SHORT, P_MID), P_LONG);
  localparam int unsigned CW   = $clog2(PMAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          enabled;

  always_comb begin
    unique case (wd_sel_e'(sel_i))
      WD_SHORT: limit = CW'(P_SHORT);
      WD_MID:   limit = CW'(P_MID);
      default:  limit = CW'(P_LONG);
    endcase
  end

  assign enabled  = (wd_sel_e'(sel_i) != WD_OFF);
  assign expire_o = enabled & ~hold_i & ~kick_i & (cnt_q == limit - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cnt_q <= '0;
    else if (hold_i || !enabled || kick_i || expire_o) cnt_q <= '0;
    else                                           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rsup_stretch.sv
module rsup_stretch
  import rsup_pkg::*;
#(
  parameter int unsigned POR_CYCLES  = 40,
  parameter int unsigned HOLD_CYCLES = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_i,
  input  logic wd_expire_i,
  output logic rst_o,
  output logic cause_wd_o
);
  localparam int unsigned CW = $clog2(max2(POR_CYCLES, HOLD_CYCLES) + 1);

  logic          active_q, por_q, cause_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit = por_q ? CW'(POR_CYCLES) : CW'(HOLD_CYCLES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      por_q    <= 1'b1;
      cnt_q    <= '0;
      cause_q  <= 1'b0;
    end else if (low_i) begin
      active_q <= 1'b1;
      por_q    <= 1'b0;
      cnt_q    <= '0;
      cause_q  <= 1'b0;
    end else if (wd_expire_i) begin
      active_q <= 1'b1;
      por_q    <= 1'b0;
      cnt_q    <= '0;
      cause_q  <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == limit - 1'b1) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_o      = active_q;
  assign cause_wd_o = cause_q;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int unsigned POR_CYCLES  = 40,
  parameter int unsigned HOLD_CYCLES = 24,
  parameter int unsigned WD_SHORT    = 60,
  parameter int unsigned WD_MID      = 100,
  parameter int unsigned WD_LONG     = 150,
  parameter int unsigned KICK_MIN    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       low_supply_i,
  input  logic       wdi_cs_ni,
  input  logic [1:0] wd_sel_i,
  output logic       sys_rst_o,
  output logic       sys_rst_no,
  output logic       cause_wd_o
);
  logic wd_kick;
  logic wd_expire;
  logic rst_q;

  rsup_kick_detect #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_LOW    (KICK_MIN)
  ) u_kick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_ni (wdi_cs_ni),
    .kick_o(wd_kick)
  );

  rsup_wdt #(
    .P_SHORT(WD_SHORT),
    .P_MID  (WD_MID),
    .P_LONG (WD_LONG)
  ) u_wdt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (rst_q),
    .sel_i   (wd_sel_i),
    .kick_i  (wd_kick),
    .expire_o(wd_expire)
  );

  rsup_stretch #(
    .POR_CYCLES (POR_CYCLES),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_stretch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .low_i      (low_supply_i),
    .wd_expire_i(wd_expire),
    .rst_o      (rst_q),
    .cause_wd_o (cause_wd_o)
  );

  assign sys_rst_o  = rst_q;
  assign sys_rst_no = ~rst_q;
endmodule

// File: rtl/rsup_checker.sv
module rsup_checker #(
  parameter int unsigned MIN_HOLD = 24
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       low_supply_i,
  input logic [1:0] wd_sel_i,
  input logic       sys_rst_o,
  input logic       sys_rst_no,
  input logic       cause_wd_o,
  input logic       wd_expire
);
  logic [15:0] hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   hi_run <= '0;
    else if (!sys_rst_o)           hi_run <= '0;
    else if (hi_run != 16'hffff)   hi_run <= hi_run + 1'b1;
  end

  p_complement_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_no == !sys_rst_o);

  p_low_asserts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_supply_i |=> sys_rst_o);

  p_low_clears_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_supply_i |=> !cause_wd_o);

  p_release_after_recovery_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> $past(!low_supply_i));

  p_wd_trip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_expire && !low_supply_i) |=> (sys_rst_o && cause_wd_o));

  p_off_never_trips_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_sel_i == 2'b11) |-> !wd_expire);

  p_min_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> (hi_run >= 16'(MIN_HOLD)));
endmodule

bind rst_supervisor rsup_checker #(
  .MIN_HOLD((POR_CYCLES < HOLD_CYCLES) ? POR_CYCLES : HOLD_CYCLES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .low_supply_i(low_supply_i),
  .wd_sel_i    (wd_sel_i),
  .sys_rst_o   (sys_rst_o),
  .sys_rst_no  (sys_rst_no),
  .cause_wd_o  (cause_wd_o),
  .wd_expire   (wd_expire)
);

// File: tb/sim_rst_supervisor.sv
`timescale 1ns/1ps
module sim_rst_supervisor;
  localparam time CLK_PERIOD = 10ns;
  localparam int POR  = 40;
  localparam int HOLD = 24;
  localparam int P10  = 60;
  localparam int P01  = 100;
  localparam int P00  = 150;
  localparam int KMIN = 3;
  localparam int LOWL = 7;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       low_supply_i = 1'b0;
  logic       wdi_cs_ni = 1'b1;
  logic [1:0] wd_sel_i = 2'b10;
  logic       sys_rst_o, sys_rst_no, cause_wd_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rst_supervisor #(
    .POR_CYCLES(POR), .HOLD_CYCLES(HOLD), .WD_SHORT(P10), .WD_MID(P01),
    .WD_LONG(P00), .KICK_MIN(KMIN), .SYNC_STAGES(2)
  ) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .low_supply_i(low_supply_i),
    .wdi_cs_ni(wdi_cs_ni), .wd_sel_i(wd_sel_i), .sys_rst_o(sys_rst_o),
    .sys_rst_no(sys_rst_no), .cause_wd_o(cause_wd_o)
  );

  typedef struct {
    int    gap;
    int    width;
    bit    cause;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   pulses = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // monitor: measure every reset pulse and the low gap before it
  int hi = 0, lo = 0, gap_seen = -1;
  bit inpulse = 1'b1;
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      hi = 0; lo = 0; gap_seen = -1; inpulse = 1'b1;
    end else if (sys_rst_o) begin
      if (!inpulse) begin
        gap_seen = lo;
        inpulse  = 1'b1;
        hi       = 0;
        check(sys_rst_no == 1'b0, "R8", sys_rst_no, 0);
      end
      hi++;
    end else begin
      if (inpulse) begin
        exp_t e;
        inpulse = 1'b0;
        lo = 0;
        pulses++;
        check(sys_rst_no == 1'b1, "R8", sys_rst_no, 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "unexpected reset pulse", hi, 0);
        end else begin
          e = exp_q.pop_front();
          check(hi == e.width, {e.tag, " width"}, hi, e.width);
          if (e.gap >= 0) check(gap_seen == e.gap, {e.tag, " gap"}, gap_seen, e.gap);
          check(cause_wd_o == e.cause, {"R9 cause after ", e.tag}, cause_wd_o, e.cause);
        end
      end
      lo++;
    end
  end

  task automatic push(input int gap, input int width, input bit cause, input string tag);
    exp_t e;
    e.gap = gap; e.width = width; e.cause = cause; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_n(input int n);
    int target = pulses + n;
    while (pulses < target) begin
      @(negedge clk_i);
      #1;
    end
  endtask

  task automatic power_cycle(input logic [1:0] sel);
    @(posedge clk_i); #1;
    rst_ni   = 1'b0;
    wd_sel_i = sel;
    @(negedge clk_i);
    check(sys_rst_o == 1'b1, "R1 reset state", sys_rst_o, 1);
    check(cause_wd_o == 1'b0, "R1 cause in reset", cause_wd_o, 0);
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
  endtask

  task automatic kick(input int k, input int n);
    repeat (k) @(posedge clk_i);
    #1 wdi_cs_ni = 1'b0;
    repeat (n) @(posedge clk_i);
    #1 wdi_cs_ni = 1'b1;
  endtask

  task automatic low_pulse(input int wait_c, input int len);
    repeat (wait_c) @(posedge clk_i);
    #1 low_supply_i = 1'b1;
    repeat (len) @(posedge clk_i);
    @(negedge clk_i);
    check(sys_rst_o == 1'b1, "R2 held during low supply", sys_rst_o, 1);
    @(posedge clk_i);
    #1 low_supply_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    push(-1, POR, 1'b0, "R1 power-on");
    push(P10, HOLD, 1'b1, "R4 code10 R5");
    wait_n(2);

    push(-1, POR, 1'b0, "R1 power-on");
    push(P01, HOLD, 1'b1, "R4 code01 R5");
    power_cycle(2'b01);
    wait_n(2);

    push(-1, POR, 1'b0, "R1 power-on");
    push(P00, HOLD, 1'b1, "R4 code00 R5");
    power_cycle(2'b00);
    wait_n(2);

    push(-1, POR, 1'b0, "R1 power-on");
    push(P10, HOLD, 1'b1, "R4 code10 R5");
    power_cycle(2'b10);
    wait_n(2);

    // R6: minimum-width kick restarts the period
    push(P10/2 + KMIN + 3 + P10, HOLD, 1'b1, "R6 valid kick");
    kick(P10/2, KMIN);
    wait_n(1);

    // R6: one cycle short is ignored
    push(P10, HOLD, 1'b1, "R6 short kick");
    kick(P10/2, KMIN - 1);
    wait_n(1);

    // R6: periodic kicks keep reset away
    p0 = pulses;
    repeat (6) kick(P10/2, KMIN);
    @(negedge clk_i);
    check(pulses == p0, "R6 no reset with kicks", pulses - p0, 0);
    push(-1, HOLD, 1'b1, "R5 after kicks stop");
    wait_n(1);

    // R2 R3 R9: low supply mid-period, then watchdog again
    push(-1, LOWL + HOLD - 1, 1'b0, "R3 low supply");
    low_pulse(10, LOWL - 1);
    wait_n(1);
    push(P10, HOLD, 1'b1, "R4 after low supply");
    wait_n(1);

    // R7: disabled watchdog
    push(-1, POR, 1'b0, "R1 power-on");
    power_cycle(2'b11);
    wait_n(1);
    p0 = pulses;
    repeat (P00 * 2) @(posedge clk_i);
    kick(5, KMIN);
    repeat (P00) @(posedge clk_i);
    @(negedge clk_i);
    check(pulses == p0, "R7 disabled no timeout", pulses - p0, 0);
    check(sys_rst_o == 1'b0, "R7 reset stays low", sys_rst_o, 0);
    push(-1, LOWL + HOLD - 1, 1'b0, "R7 R3 low supply when disabled");
    low_pulse(3, LOWL - 1);
    wait_n(1);

    repeat (5) @(negedge clk_i);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule